// File: doc/BRIEF.md
# Tiled depth-stencil pixel access unit

This block turns single-pixel depth and stencil accesses into memory transactions on a tiled or linear depth surface. Each request carries window-relative coordinates, a format and a write value. The surface settings (window origin, pitch in pixels, linear/tiled selection) are sampled together with the request. The block adds the origin to the coordinates and computes the byte address of the pixel. It then drives a 32-bit memory port that uses a request/acknowledge handshake. Two pixel formats are supported: a 16-bit depth format, and a packed 32-bit format with depth in the low 24 bits and stencil in the top 8 bits.

In the packed format, a depth write and a stencil write each change only their own field. The block reads the word, merges the new field in, and writes the word back. Nothing else is allowed onto the memory port between that read and that write. Every request, read or write, finishes with one response on a valid/ready handshake. A request whose surface settings cannot be served is answered with an error flag and makes no memory access. Only one request is handled at a time.

Top module: `zs_access_unit`

## Requirements
- R1: The effective coordinates are (req_x + cfg_org_x) and (req_y + cfg_org_y), each taken modulo 2^12 at the default widths. All request fields and all cfg_* inputs are sampled in the cycle where req_valid and req_ready are both high.
- R2: When cfg_linear=1, the pixel address is 4*(x + y*pitch) for the packed format (req_fmt32=1) and 2*(x + y*pitch) for the 16-bit format.
- R3: Tiled packed format. With T = (y/16)*(pitch/16) + x/16, the address is built as follows:
  - bits 1:0 are 0;
  - bits 4:2 are x[2:0];
  - bits 6:5 are y[1:0];
  - bit 7 is x[4]^y[2];
  - bits 9:8 are T[1:0];
  - bit 10 is y[3];
  - bit 11 is x[3]^y[4];
  - bits from 12 upward are T>>2.
- R4: Tiled 16-bit format. With T = (y/16)*(pitch/32) + x/32, the address is built as follows:
  - bit 0 is 0;
  - bits 3:1 are x[2:0];
  - bits 6:4 are y[2:0];
  - bit 7 is x[3];
  - bits 9:8 are T[1:0];
  - bit 10 is y[3];
  - bit 11 is x[4]^y[4];
  - bits from 12 upward are T>>2.
- R5: A packed depth write (req_stencil=0) makes two word accesses to the same address, a read and then a write. The written word keeps the old bits 31:24 and puts req_wdata[23:0] in bits 23:0.
- R6: A packed stencil write (req_stencil=1) makes the same read and then write. The written word keeps the old bits 23:0 and puts req_wdata[7:0] in bits 31:24.
- R7: A packed depth read returns bits 23:0 of the word, zero-extended. A packed stencil read returns bits 31:24 moved down to bit 0. Every write returns rsp_data=0.
- R8: A 16-bit access makes exactly one halfword transaction (mem_size=0) and no merge. Write data goes out in mem_wdata[15:0] with mem_wdata[31:16]=0. A read returns mem_rdata[15:0] zero-extended, and mem_rdata[31:16] is ignored.
- R9: A request is refused with rsp_err=1, rsp_data=0 and no memory transaction in two cases: a stencil access in the 16-bit format, or a tiled access whose pitch is not a multiple of 16 (packed format) or 32 (16-bit format).
- R10: req_ready is low from the cycle after acceptance until the cycle after the response handshake. Between the read and the write of a merge, no new request is accepted.
- R11: mem_req stays high, with mem_addr, mem_we, mem_size and mem_wdata stable, until the cycle in which mem_ack is high. Any number of wait cycles is allowed.
- R12: rsp_valid stays high, with rsp_data and rsp_err stable, until rsp_ready is high.
- R13: After a reset cycle, req_ready=1, mem_req=0 and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_stencil | input | 1 | 1 = stencil field, 0 = depth |
| req_fmt32 | input | 1 | 1 = packed 24+8 word, 0 = 16-bit depth |
| req_x | input | 12 | Window-relative x |
| req_y | input | 12 | Window-relative y |
| req_wdata | input | 24 | Write value (low 16 or low 8 bits used per format/field) |
| cfg_linear | input | 1 | 1 = linear surface, 0 = tiled |
| cfg_pitch | input | 12 | Surface pitch in pixels |
| cfg_org_x | input | 12 | Window origin x |
| cfg_org_y | input | 12 | Window origin y |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write |
| mem_size | output | 1 | 1 = 32-bit word, 0 = 16-bit halfword |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transaction completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 32 | Read result, zero for writes and errors |
| rsp_err | output | 1 | Request refused |

## Verification
The hardest case to reach from the ports is a packed write whose read and write phases both stall on the memory port, while the response side also stalls. Only in that case can a broken design leak a second request into the merge or corrupt the field it was told to keep. The bench's memory model inserts a random 0 to 3 cycle acknowledge delay on every phase and withholds rsp_ready at random. Directed pairs are mixed into the random stream: a depth write and a stencil write to the same pixel, each followed by reads of both fields. The stream also includes pitches that are legal for one format and illegal for the other, such as 48, and origin offsets that wrap the coordinate range.

// File: rtl/zs_pkg.sv
// zs_pkg: shared widths and the sequencer state type for the depth-stencil
// access unit. Assumes a 32-bit memory word holding 24 depth + 8 stencil bits.
package zs_pkg;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int DEPTH_W = 24;
    localparam int STEN_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DECIDE = 3'd1,
        ST_RD     = 3'd2,
        ST_WR     = 3'd3,
        ST_RSP    = 3'd4
    } zs_state_e;
endpackage

// File: rtl/zs_addr_gen.sv
// zs_addr_gen: byte address of one pixel in a linear or tiled depth surface,
// plus the pitch legality flag for tiled mode. Purely combinational.
// Assumes x, y already include the window origin and AW >= 13.
module zs_addr_gen #(
    parameter int XW = 12,
    parameter int YW = 12,
    parameter int PW = 12,
    parameter int AW = 32
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic [PW-1:0] pitch,
    input  logic          fmt32,
    input  logic          linear,
    output logic [AW-1:0] addr,
    output logic          pitch_ok
);
    logic [AW-1:0] lin_idx;
    logic [AW-1:0] tile32;
    logic [AW-1:0] tile16;
    logic [AW-1:0] lin_addr;
    logic [AW-1:0] til_addr32;
    logic [AW-1:0] til_addr16;

    // Linear pixel index and its byte address for either pixel size
    always_comb begin
        lin_idx  = AW'(x) + AW'(y) * AW'(pitch);
        lin_addr = fmt32 ? {lin_idx[AW-3:0], 2'b00} : {lin_idx[AW-2:0], 1'b0};
    end

    // Tile indices: 16x16 tiles for 32-bit pixels, 32x16 tiles for 16-bit pixels
    always_comb begin
        tile32 = AW'(y[YW-1:4]) * AW'(pitch[PW-1:4]) + AW'(x[XW-1:4]);
        tile16 = AW'(y[YW-1:4]) * AW'(pitch[PW-1:5]) + AW'(x[XW-1:5]);
    end

    // Bit interleave of coordinates and tile index inside each 4 KiB group
    always_comb begin
        til_addr32 = {tile32[AW-11:2], x[3] ^ y[4], y[3], tile32[1:0],
                      x[4] ^ y[2], y[1:0], x[2:0], 2'b00};
        til_addr16 = {tile16[AW-11:2], x[4] ^ y[4], y[3], tile16[1:0],
                      x[3], y[2:0], x[2:0], 1'b0};
    end

    // Final address select and tiled pitch alignment check
    always_comb begin
        if (linear)     addr = lin_addr;
        else if (fmt32) addr = til_addr32;
        else            addr = til_addr16;
        pitch_ok = linear | (fmt32 ? (pitch[3:0] == 4'd0) : (pitch[4:0] == 5'd0));
    end
endmodule

// File: rtl/zs_field_merge.sv
// zs_field_merge: builds the word written back for a depth or stencil update
// and extracts the returned field from a read word. Combinational.
// Assumes packed layout: depth in the low DEPTH_W bits, stencil above it.
module zs_field_merge import zs_pkg::*; (
    input  logic               fmt32,
    input  logic               sten,
    input  logic [WORD_W-1:0]  old_word,
    input  logic [DEPTH_W-1:0] new_val,
    output logic [WORD_W-1:0]  wr_word,
    output logic [WORD_W-1:0]  rd_val
);
    // Per-format merge of the new field and extraction of the read field
    always_comb begin
        if (!fmt32) begin
            wr_word = {{(WORD_W-HALF_W){1'b0}}, new_val[HALF_W-1:0]};
            rd_val  = {{(WORD_W-HALF_W){1'b0}}, old_word[HALF_W-1:0]};
        end else if (sten) begin
            wr_word = {new_val[STEN_W-1:0], old_word[DEPTH_W-1:0]};
            rd_val  = {{(WORD_W-STEN_W){1'b0}}, old_word[WORD_W-1:DEPTH_W]};
        end else begin
            wr_word = {old_word[WORD_W-1:DEPTH_W], new_val};
            rd_val  = {{STEN_W{1'b0}}, old_word[DEPTH_W-1:0]};
        end
    end
endmodule

// File: rtl/zs_seq.sv
// zs_seq: request sequencer. Accept, decide (error / read first / write only),
// memory read, memory write, respond. Holds one request at a time so a
// read-modify-write cannot be split by another request.
module zs_seq import zs_pkg::*; (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept,
    input  logic      err,
    input  logic      need_rd,
    input  logic      is_wr,
    input  logic      mem_ack,
    input  logic      rsp_ready,
    output zs_state_e state
);
    zs_state_e nxt;

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (accept) nxt = ST_DECIDE;
            ST_DECIDE: nxt = err ? ST_RSP : (need_rd ? ST_RD : ST_WR);
            ST_RD:     if (mem_ack) nxt = is_wr ? ST_WR : ST_RSP;
            ST_WR:     if (mem_ack) nxt = ST_RSP;
            ST_RSP:    if (rsp_ready) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/zs_access_unit.sv
// zs_access_unit: per-pixel depth/stencil access to a tiled or linear depth
// surface over a req/ack memory port with a valid/ready response.
// Assumes the memory returns halfword data in the low 16 bits and that
// surface configuration is valid in the request acceptance cycle.
module zs_access_unit import zs_pkg::*; #(
    parameter int XW = 12,
    parameter int YW = 12,
    parameter int PW = 12,
    parameter int AW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic               req_stencil,
    input  logic               req_fmt32,
    input  logic [XW-1:0]      req_x,
    input  logic [YW-1:0]      req_y,
    input  logic [DEPTH_W-1:0] req_wdata,
    input  logic               cfg_linear,
    input  logic [PW-1:0]      cfg_pitch,
    input  logic [XW-1:0]      cfg_org_x,
    input  logic [YW-1:0]      cfg_org_y,
    output logic               mem_req,
    output logic               mem_we,
    output logic               mem_size,
    output logic [AW-1:0]      mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [WORD_W-1:0]  rsp_data,
    output logic               rsp_err
);
    zs_state_e          state;
    logic               accept;
    logic               op_write;
    logic               op_sten;
    logic               op_fmt32;
    logic               op_linear;
    logic [XW-1:0]      op_x;
    logic [YW-1:0]      op_y;
    logic [PW-1:0]      op_pitch;
    logic [DEPTH_W-1:0] op_wdata;
    logic [WORD_W-1:0]  rd_word;
    logic               pitch_ok;
    logic               op_err;
    logic [WORD_W-1:0]  merged;
    logic [WORD_W-1:0]  field;

    assign accept = req_valid & req_ready;

    // Capture request and surface settings, with origin already added
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_write  <= 1'b0;
            op_sten   <= 1'b0;
            op_fmt32  <= 1'b0;
            op_linear <= 1'b0;
            op_x      <= '0;
            op_y      <= '0;
            op_pitch  <= '0;
            op_wdata  <= '0;
        end else if (accept) begin
            op_write  <= req_write;
            op_sten   <= req_stencil;
            op_fmt32  <= req_fmt32;
            op_linear <= cfg_linear;
            op_x      <= req_x + cfg_org_x;
            op_y      <= req_y + cfg_org_y;
            op_pitch  <= cfg_pitch;
            op_wdata  <= req_wdata;
        end
    end

    // Hold the memory word returned by the read phase
    always_ff @(posedge clk) begin
        if (!rst_n)                           rd_word <= '0;
        else if (state == ST_RD && mem_ack)   rd_word <= mem_rdata;
    end

    zs_addr_gen #(.XW(XW), .YW(YW), .PW(PW), .AW(AW)) u_addr (
        .x        (op_x),
        .y        (op_y),
        .pitch    (op_pitch),
        .fmt32    (op_fmt32),
        .linear   (op_linear),
        .addr     (mem_addr),
        .pitch_ok (pitch_ok)
    );

    zs_field_merge u_merge (
        .fmt32    (op_fmt32),
        .sten     (op_sten),
        .old_word (rd_word),
        .new_val  (op_wdata),
        .wr_word  (merged),
        .rd_val   (field)
    );

    // Refuse stencil in 16-bit format and misaligned tiled pitch
    assign op_err = (op_sten & ~op_fmt32) | ~pitch_ok;

    zs_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .err       (op_err),
        .need_rd   (~op_write | op_fmt32),
        .is_wr     (op_write),
        .mem_ack   (mem_ack),
        .rsp_ready (rsp_ready),
        .state     (state)
    );

    // Port decode from sequencer state
    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_req   = (state == ST_RD) || (state == ST_WR);
        mem_we    = (state == ST_WR);
        mem_size  = op_fmt32;
        mem_wdata = (state == ST_WR) ? merged : '0;
        rsp_valid = (state == ST_RSP);
        rsp_err   = rsp_valid & op_err;
        rsp_data  = (rsp_valid && !op_write && !op_err) ? field : '0;
    end
endmodule

// File: rtl/zs_access_unit_chk.sv
// zs_access_unit_chk: protocol and ordering properties of the access unit,
// attached to every instance by the bind below.
module zs_access_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_size,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [31:0]   rsp_data,
    input logic          rsp_err
);
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || rsp_valid) |-> !req_ready); // R10
    AST_RMW_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we) |=> !req_ready); // R10
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_size) && $stable(mem_wdata))); // R11
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err))); // R12
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_size) |-> (mem_addr[1:0] == 2'b00)); // R3
    AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_size) |-> !mem_addr[0]); // R4
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_data == 32'd0)); // R9
    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_req); // R10
endmodule

bind zs_access_unit zs_access_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_zs_access_unit.sv
// tb_zs_access_unit: behavioural memory and response model compared every cycle.
module tb_zs_access_unit;
    localparam int CLK_PERIOD = 10;
    localparam int XW = 12, YW = 12, PW = 12, AW = 32;

    logic clk, rst_n;
    logic req_valid, req_ready, req_write, req_stencil, req_fmt32;
    logic [XW-1:0] req_x, cfg_org_x;
    logic [YW-1:0] req_y, cfg_org_y;
    logic [23:0] req_wdata;
    logic cfg_linear;
    logic [PW-1:0] cfg_pitch;
    logic mem_req, mem_we, mem_size, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic rsp_valid, rsp_ready, rsp_err;
    logic [31:0] rsp_data;

    zs_access_unit #(.XW(XW), .YW(YW), .PW(PW), .AW(AW)) dut (.*);

    typedef struct {bit wr, st, f32, lin; int unsigned x, y, pitch, ox, oy; bit [23:0] wd;} rq_t;
    typedef struct {bit [31:0] addr; bit we, sz; bit [31:0] wd; string tag;} mx_t;
    typedef struct {bit [31:0] data; bit err; string tag;} rx_t;

    rq_t pend[$];
    mx_t mq[$];
    rx_t rq[$];
    bit [31:0] memw [int unsigned];
    int n_tests = 0, n_fail = 0;
    bit busy = 0, acked = 0, done = 0;
    int lat = -1;

    initial begin clk = 0; forever #(CLK_PERIOD/2) clk = ~clk; end

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit [31:0] mword(int unsigned wa);
        if (memw.exists(wa)) return memw[wa];
        return (wa * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic int unsigned ref_addr(bit f32, bit lin, int unsigned x, int unsigned y, int unsigned p);
        int unsigned ba;
        if (lin) return (f32 ? 4 : 2) * (x + y * p);
        if (f32) begin
            ba = (y / 16) * (p / 16) + x / 16;
            return (x % 8) * 4 + (y % 4) * 32 + (((x / 16) % 2) ^ ((y / 4) % 2)) * 128
                 + (ba % 4) * 256 + ((y / 8) % 2) * 1024
                 + (((x / 8) % 2) ^ ((y / 16) % 2)) * 2048 + (ba / 4) * 4096;
        end
        ba = (y / 16) * (p / 32) + x / 32;
        return (x % 8) * 2 + (y % 8) * 16 + ((x / 8) % 2) * 128 + (ba % 4) * 256
             + ((y / 8) % 2) * 1024 + (((x / 16) % 2) ^ ((y / 16) % 2)) * 2048 + (ba / 4) * 4096;
    endfunction

    function automatic rq_t mk(bit wr, bit st, bit f32, bit lin, int unsigned x, int unsigned y,
                               int unsigned p, int unsigned ox, int unsigned oy, bit [23:0] wd);
        rq_t r;
        r.wr = wr; r.st = st; r.f32 = f32; r.lin = lin; r.x = x; r.y = y;
        r.pitch = p; r.ox = ox; r.oy = oy; r.wd = wd;
        return r;
    endfunction

    // Build expected memory transactions and response from the model memory
    task automatic predict(rq_t r);
        int unsigned xe, ye, a;
        bit err;
        bit [31:0] w, nw;
        bit [15:0] h;
        string atag;
        mx_t m;
        rx_t x;
        xe = (r.x + r.ox) % 4096;
        ye = (r.y + r.oy) % 4096;
        err = (r.st && !r.f32) || (!r.lin && (r.f32 ? (r.pitch % 16) != 0 : (r.pitch % 32) != 0));
        a = ref_addr(r.f32, r.lin, xe, ye, r.pitch);
        atag = r.lin ? "R2" : (r.f32 ? "R3" : "R4");
        if (r.ox != 0 || r.oy != 0) atag = {"R1 ", atag};
        w = mword(a / 4);
        h = (a % 4 >= 2) ? w[31:16] : w[15:0];
        if (err) begin
            x.data = 0; x.err = 1; x.tag = "R9"; rq.push_back(x);
            return;
        end
        x.err = 0;
        m.addr = a; m.sz = r.f32; m.wd = 0;
        if (!r.f32) begin
            m.we = r.wr; m.tag = {"R8 ", atag};
            if (r.wr) m.wd = {16'h0, r.wd[15:0]};
            mq.push_back(m);
            x.data = r.wr ? 32'h0 : {16'h0, h}; x.tag = "R8";
        end else begin
            m.we = 0; m.tag = atag; mq.push_back(m);
            if (r.wr) begin
                nw = r.st ? {r.wd[7:0], w[23:0]} : {w[31:24], r.wd};
                m.we = 1; m.wd = nw; m.tag = r.st ? {"R6 ", atag} : {"R5 ", atag};
                mq.push_back(m);
                x.data = 0; x.tag = "R7 write";
            end else begin
                x.data = r.st ? {24'h0, w[31:24]} : {8'h0, w[23:0]};
                x.tag = r.st ? "R7 stencil" : "R7 depth";
            end
        end
        rq.push_back(x);
    endtask

    // Per-cycle model: ready check, memory responder, response sink, request driver
    always @(negedge clk) begin
        if (rst_n) begin
            chk(req_ready == !busy, "R10", "req_ready", {31'h0, req_ready}, {31'h0, !busy});
            if (acked) begin
                mem_ack = 0; acked = 0;
            end else if (mem_req) begin
                mx_t e;
                string t;
                if (mq.size() == 0) begin
                    chk(0, "R9", "unexpected mem_req", {31'h0, mem_req}, 32'h0);
                    e.addr = mem_addr; e.we = mem_we; e.sz = mem_size; e.wd = mem_wdata; e.tag = "R9";
                end else e = mq[0];
                if (lat < 0) lat = $urandom_range(0, 3);
                t = (lat > 0) ? {"R11 ", e.tag} : e.tag;
                chk(mem_addr == e.addr, t, "mem_addr", mem_addr, e.addr);
                chk(mem_we == e.we, t, "mem_we", {31'h0, mem_we}, {31'h0, e.we});
                chk(mem_size == e.sz, t, "mem_size", {31'h0, mem_size}, {31'h0, e.sz});
                if (e.we) chk(mem_wdata == e.wd, t, "mem_wdata", mem_wdata, e.wd);
                if (lat == 0) begin
                    bit [31:0] w;
                    w = mword(mem_addr / 4);
                    if (mem_we) begin
                        if (mem_size) w = mem_wdata;
                        else if (mem_addr[1]) w[31:16] = mem_wdata[15:0];
                        else w[15:0] = mem_wdata[15:0];
                        memw[mem_addr / 4] = w;
                    end else begin
                        mem_rdata = mem_size ? w : {16'hDEAD, (mem_addr[1] ? w[31:16] : w[15:0])};
                    end
                    mem_ack = 1; acked = 1; lat = -1;
                    if (mq.size() != 0) void'(mq.pop_front());
                end else lat--;
            end
            rsp_ready = ($urandom_range(0, 9) < 7);
            if (rsp_valid) begin
                if (rq.size() == 0) chk(0, "R10", "unexpected rsp_valid", 32'h1, 32'h0);
                else begin
                    string t;
                    t = rsp_ready ? rq[0].tag : {"R12 ", rq[0].tag};
                    chk(rsp_data == rq[0].data, t, "rsp_data", rsp_data, rq[0].data);
                    chk(rsp_err == rq[0].err, t, "rsp_err", {31'h0, rsp_err}, {31'h0, rq[0].err});
                    if (rsp_ready) begin void'(rq.pop_front()); busy = 0; end
                end
            end
            if (req_valid) req_valid = 0;
            if (!busy && pend.size() > 0 && req_ready) begin
                rq_t r;
                r = pend.pop_front();
                req_write = r.wr; req_stencil = r.st; req_fmt32 = r.f32; cfg_linear = r.lin;
                req_x = XW'(r.x); req_y = YW'(r.y); cfg_pitch = PW'(r.pitch);
                cfg_org_x = XW'(r.ox); cfg_org_y = YW'(r.oy); req_wdata = r.wd;
                req_valid = 1; busy = 1;
                predict(r);
            end
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_stencil = 0; req_fmt32 = 0;
        req_x = 0; req_y = 0; req_wdata = 0; cfg_linear = 0; cfg_pitch = 0;
        cfg_org_x = 0; cfg_org_y = 0; mem_ack = 0; mem_rdata = 0; rsp_ready = 0;
        // packed merge pair on one pixel, then both fields read back (R5 R6 R7)
        pend.push_back(mk(1, 0, 1, 0, 1, 2, 64, 0, 0, 24'hABCDEF));
        pend.push_back(mk(1, 1, 1, 0, 1, 2, 64, 0, 0, 24'h000077));
        pend.push_back(mk(0, 0, 1, 0, 1, 2, 64, 0, 0, 0));
        pend.push_back(mk(0, 1, 1, 0, 1, 2, 64, 0, 0, 0));
        // tiled packed bit map corners (R3)
        pend.push_back(mk(0, 0, 1, 0, 31, 31, 64, 0, 0, 0));
        pend.push_back(mk(0, 0, 1, 0, 16, 4, 64, 0, 0, 0));
        pend.push_back(mk(0, 1, 1, 0, 8, 16, 128, 0, 0, 0));
        pend.push_back(mk(1, 0, 1, 0, 100, 50, 128, 0, 0, 24'h123456));
        // tiled 16-bit (R4 R8)
        pend.push_back(mk(1, 0, 0, 0, 31, 31, 64, 0, 0, 24'hFF1234));
        pend.push_back(mk(0, 0, 0, 0, 31, 31, 64, 0, 0, 0));
        pend.push_back(mk(0, 0, 0, 0, 40, 17, 96, 0, 0, 0));
        pend.push_back(mk(0, 0, 0, 0, 9, 8, 64, 0, 0, 0));
        // linear with a pitch illegal for tiling (R2)
        pend.push_back(mk(0, 0, 1, 1, 5, 7, 37, 0, 0, 0));
        pend.push_back(mk(1, 0, 0, 1, 3, 2, 37, 0, 0, 24'h00BEEF));
        pend.push_back(mk(0, 0, 0, 1, 3, 2, 37, 0, 0, 0));
        // origin add with wrap (R1)
        pend.push_back(mk(0, 0, 1, 0, 4090, 5, 64, 10, 20, 0));
        pend.push_back(mk(1, 1, 1, 0, 7, 4095, 64, 100, 3, 24'h0000C3));
        // refusals (R9): misaligned pitch, 48 legal only for packed, stencil in 16-bit
        pend.push_back(mk(1, 0, 1, 0, 1, 1, 40, 0, 0, 24'h111111));
        pend.push_back(mk(0, 0, 0, 0, 1, 1, 48, 0, 0, 0));
        pend.push_back(mk(0, 0, 1, 0, 1, 1, 48, 0, 0, 0));
        pend.push_back(mk(0, 1, 0, 0, 1, 1, 64, 0, 0, 0));
        pend.push_back(mk(1, 1, 0, 1, 1, 1, 64, 0, 0, 24'h000055));
        for (int i = 0; i < 300; i++) begin
            bit f32, st;
            int unsigned p;
            f32 = $urandom_range(0, 1);
            st = f32 ? bit'($urandom_range(0, 1)) : ($urandom_range(0, 7) == 0);
            p = 32 * $urandom_range(1, 6);
            if ($urandom_range(0, 7) == 0) p = p + $urandom_range(1, 31);
            pend.push_back(mk($urandom_range(0, 1), st, f32, ($urandom_range(0, 3) == 0),
                              $urandom_range(0, 63), $urandom_range(0, 63), p,
                              ($urandom_range(0, 5) == 0) ? $urandom_range(4000, 4095) : $urandom_range(0, 3),
                              $urandom_range(0, 3), 24'($urandom())));
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R13", "req_ready after reset", {31'h0, req_ready}, 32'h1);
        chk(mem_req == 1'b0, "R13", "mem_req after reset", {31'h0, mem_req}, 32'h0);
        chk(rsp_valid == 1'b0, "R13", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        #1 rst_n = 1;
        wait (pend.size() == 0 && !busy);
        repeat (4) @(posedge clk);
        chk(mq.size() == 0, "R9", "leftover mem ops", mq.size(), 0);
        done = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(0, "R10", "watchdog expired", 0, 1);
            summary();
        end
    end
endmodule